// File: doc/BRIEF.md
# Interpolating Half-Sine Table Oscillator

A numerically controlled sine oscillator that advances once per audio sample strobe. A 24-bit phase accumulator holds a 16-bit integer part above an 8-bit fraction. Each strobe adds a 16-bit frequency word to it, entering at the lowest fraction bit.

Only half a sine period is stored. The other half is produced by negating table reads. Two neighbouring entries are read for every sample, each sign-corrected from its own half-select bit. They are then blended linearly by the fractional phase, which gives sub-entry frequency resolution.

The result is a signed 16-bit sample, registered, with a one-cycle valid pulse. The table is computed at elaboration by a synthesizable integer function.

Top module: `hsine_nco`

## Requirements
- R1: A synchronous active-high `rst` clears the phase to zero and drives `sample` to 0 and `sample_vld` to 0. Reset takes priority over a simultaneous `tick`.
- R2: On each clock edge with `tick` high, the 24-bit phase becomes (phase + `step_inc`) mod 2^24, with `step_inc` zero-extended and added at bit 0. With `tick` low, the phase and the value of `step_inc` have no effect.
- R3: `sample_vld` is high exactly in the cycle after an edge on which `tick` was high, and low otherwise. `sample` changes only on such edges and holds its value in between.
- R4: Table entry k (0 ≤ k < 512) equals floor(32767·16·n / (5·512² − 4·n)), with n = k·(512 − k). Entry 0 is 0 and entry 256 is 32767.
- R5: The first tap uses integer phase P. Its index is P[8:0], and the entry is negated when P[9] is 1.
- R6: The second tap uses P+1 (mod 2^16). Its index is (P+1)[8:0], and it is negated when its own bit 9 is 1, independently of the first tap.
- R7: With fraction f = phase[7:0], `sample` = floor((tap1·(255 − f) + tap2·f) / 256), computed on the phase after the increment of the same tick. The first tap is weighted by 255 − f.
- R8: With `step_inc` = 0x0100, the output sequence repeats every 1024 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe; advances phase and produces one sample |
| step_inc | input | 16 | Frequency increment added to the phase on each tick |
| sample | output | 16 | Signed interpolated sine sample |
| sample_vld | output | 1 | One-cycle pulse marking a new sample |

## Verification
Phase advance and output production fall on the same edge, because the sample is taken from the freshly incremented phase. Feeding continuous back-to-back ticks therefore checks that each sample reflects the current increment and not a stale phase.

Reset and a tick can also collide. The bench asserts both together mid-run with a non-zero increment, then expects zero outputs followed by a first sample computed from phase zero.

Sweeps with increments of 0x0001, 0x0100, 0x0137 and 0xFFFF push the taps across the half-period sign boundary and the 24-bit wrap. Every sample is judged against a bench model of the table formula, sign rule and weighting.

// File: rtl/hsnco_pkg.sv
`timescale 1ns/1ps
package hsnco_pkg;

  // Rational sine approximation over half a period, integer-only so it
  // elaborates in any tool. Peaks at amp when k = depth/2.
  function automatic longint hs_entry(input longint k, input longint depth,
                                      input longint amp);
    longint n;
    n = k * (depth - k);
    return (16 * amp * n) / (5 * depth * depth - 4 * n);
  endfunction

endpackage

// File: rtl/hsnco_phase.sv
`timescale 1ns/1ps
module hsnco_phase #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 16,
  parameter int INC_W  = 16,
  parameter int TAB_AW = 9,
  localparam int PH_W   = FRAC_W + INT_W,
  localparam int LOOK_W = FRAC_W + TAB_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [INC_W-1:0]  step_inc,
  output logic [LOOK_W-1:0] look_o
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_nxt;

  assign phase_nxt = phase_q + PH_W'(step_inc);
  assign look_o    = phase_nxt[LOOK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (tick) phase_q <= phase_nxt;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> phase_q == '0);

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase_q));

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase_q == PH_W'($past(phase_q) + PH_W'($past(step_inc))));

endmodule

// File: rtl/hsnco_taps.sv
`timescale 1ns/1ps
module hsnco_taps #(
  parameter int TAB_AW = 9,
  parameter int DW     = 16,
  localparam int DEPTH = 2 ** TAB_AW,
  localparam int AW1   = TAB_AW + 1,
  localparam longint AMP = (longint'(1) <<< (DW - 1)) - 1
) (
  input  logic [AW1-1:0]       ipos,
  output logic signed [DW-1:0] tap_a,
  output logic signed [DW-1:0] tap_b
);

  logic signed [DW-1:0] rom [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++)
      rom[k] = DW'(hsnco_pkg::hs_entry(longint'(k), longint'(DEPTH), AMP));
  end

  logic signed [DW-1:0] taps [2];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [AW1-1:0]       addr;
    logic signed [DW-1:0] mag;
    assign addr    = ipos + AW1'(p);
    assign mag     = rom[addr[TAB_AW-1:0]];
    assign taps[p] = addr[TAB_AW] ? -mag : mag;
  end

  assign tap_a = taps[0];
  assign tap_b = taps[1];

endmodule

// File: rtl/hsnco_interp.sv
`timescale 1ns/1ps
module hsnco_interp #(
  parameter int DW     = 16,
  parameter int FRAC_W = 8,
  localparam int ACC_W = DW + FRAC_W
) (
  input  logic signed [DW-1:0] tap_a,
  input  logic signed [DW-1:0] tap_b,
  input  logic [FRAC_W-1:0]    frac,
  output logic signed [DW-1:0] mix_o
);

  logic signed [ACC_W-1:0] w_a, w_b, prod_a, prod_b, acc;
  logic unused_lo;

  assign w_a    = ACC_W'($signed({1'b0, ~frac}));
  assign w_b    = ACC_W'($signed({1'b0, frac}));
  assign prod_a = ACC_W'(tap_a) * w_a;
  assign prod_b = ACC_W'(tap_b) * w_b;
  assign acc    = prod_a + prod_b;
  assign mix_o  = acc[ACC_W-1:FRAC_W];
  assign unused_lo = ^acc[FRAC_W-1:0];

endmodule

// File: rtl/hsine_nco.sv
`timescale 1ns/1ps
module hsine_nco #(
  parameter int FRAC_W = 8,
  parameter int INT_W  = 16,
  parameter int INC_W  = 16,
  parameter int TAB_AW = 9,
  parameter int DW     = 16,
  localparam int LOOK_W = FRAC_W + TAB_AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [INC_W-1:0]     step_inc,
  output logic signed [DW-1:0] sample,
  output logic                 sample_vld
);

  logic [LOOK_W-1:0]    look;
  logic signed [DW-1:0] tap_a, tap_b, mix;

  hsnco_phase #(.FRAC_W(FRAC_W), .INT_W(INT_W), .INC_W(INC_W),
                .TAB_AW(TAB_AW)) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .step_inc(step_inc), .look_o(look)
  );

  hsnco_taps #(.TAB_AW(TAB_AW), .DW(DW)) u_taps (
    .ipos(look[LOOK_W-1:FRAC_W]), .tap_a(tap_a), .tap_b(tap_b)
  );

  hsnco_interp #(.DW(DW), .FRAC_W(FRAC_W)) u_interp (
    .tap_a(tap_a), .tap_b(tap_b), .frac(look[FRAC_W-1:0]), .mix_o(mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= tick;
      if (tick) sample <= mix;
    end
  end

  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (sample == '0 && !sample_vld));

  assert_vld_follows_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> sample_vld);

  assert_vld_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !sample_vld);

  assert_sample_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sample));

  assert_sign_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && tap_a >= 0 && tap_b >= 0) |=> !sample[DW-1]);

  assert_sign_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && tap_a <= 0 && tap_b <= 0) |=> (sample <= 0));

endmodule

// File: tb/hsine_nco_tb.sv
`timescale 1ns/1ps
module hsine_nco_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] step_inc = '0;
  logic signed [15:0] sample;
  logic        sample_vld;

  int errors = 0;
  int checks = 0;
  int model  = 0;
  int last   = 0;
  int period_buf [1024];

  always #2 clk = ~clk;

  hsine_nco u_dut (
    .clk(clk), .rst(rst), .tick(tick), .step_inc(step_inc),
    .sample(sample), .sample_vld(sample_vld)
  );

  function automatic int tbl(input int k);
    longint n;
    n = longint'(k) * (512 - k);
    return int'((longint'(32767) * 16 * n) / (longint'(5) * 512 * 512 - 4 * n));
  endfunction

  function automatic int tap(input int ip);
    int v;
    v = tbl(ip & 511);
    if (((ip >> 9) & 1) == 1) v = -v;
    return v;
  endfunction

  function automatic int calc(input int ph);
    int f, ip, s;
    f  = ph & 255;
    ip = (ph >> 8) & 16'hFFFF;
    s  = tap(ip) * (255 - f) + tap((ip + 1) & 16'hFFFF) * f;
    return s >>> 8;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (phase=%06h)", tag, act, exp, model);
    end
  endtask

  // Called at a negedge; drives inputs, checks at the following negedge.
  task automatic step(input logic stb, input logic [15:0] iv, input string tag);
    tick = stb;
    step_inc = iv;
    @(negedge clk);
    if (stb) begin
      model = (model + int'(iv)) & 24'hFFFFFF;
      last  = calc(model);
      chk(tag, int'(sample_vld), 1);
      chk(tag, int'(sample), last);
    end else begin
      chk(tag, int'(sample_vld), 0);
      chk(tag, int'(sample), last);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1", int'(sample_vld), 0);
    chk("R1", int'(sample), 0);
    rst = 1'b0;
    model = 0; last = 0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R4 spot values of the table formula
    chk("R4", tbl(0), 0);
    chk("R4", tbl(256), 32767);

    // R8: one entry per tick; first half R4, second half negated R5
    for (int i = 0; i < 2048; i++) begin
      if (i < 512)       step(1'b1, 16'h0100, "R4");
      else if (i < 1024) step(1'b1, 16'h0100, "R5");
      else               step(1'b1, 16'h0100, "R8");
      if (i < 1024) period_buf[i] = last;
      else chk("R8", last, period_buf[i - 1024]);
    end

    // R7: every fraction across two table entries
    do_reset();
    for (int i = 0; i < 600; i++) step(1'b1, 16'h0001, "R7");

    // R6: odd step crossing half-period boundaries
    for (int i = 0; i < 700; i++) step(1'b1, 16'h0137, "R6");

    // R2: large step, wraps the 24-bit phase many times
    for (int i = 0; i < 600; i++) step(1'b1, 16'hFFFF, "R2");

    // R3 and R2: gaps with changing increment must not move the phase
    for (int i = 0; i < 200; i++) begin
      step(1'b0, 16'(i * 97 + 5), "R3");
      step(1'b0, 16'hABCD, "R2");
      step(1'b1, 16'h1234, "R3");
    end

    // R1: reset coinciding with a tick wins
    rst = 1'b1; tick = 1'b1; step_inc = 16'h0500;
    @(negedge clk);
    chk("R1", int'(sample_vld), 0);
    chk("R1", int'(sample), 0);
    rst = 1'b0; tick = 1'b0;
    model = 0; last = 0;
    @(negedge clk);
    chk("R1", int'(sample_vld), 0);
    step(1'b1, 16'h0100, "R1");
    chk("R1", last, (tbl(1) * 255) >>> 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule